// File: doc/BRIEF.md
# Banked Supervisor Register Exchange Unit

This block holds two copies of a small set of supervisor control and status registers. The foreground copy is what an ordinary supervisor access sees. The background copy is reached only through a second address window, and only from hypervisor-level code. The block also tracks the hart's privilege mode in a five-state machine: machine (`MD_M`), hypervisor supervisor (`MD_HS`), host user (`MD_U`), guest supervisor (`MD_VS`) and guest user (`MD_VU`). A `virt` output is high in the two guest modes.

Every register is a foreground/background pair, so one supervisor address space can serve both the hypervisor and a guest. When the hart crosses between the host world (`MD_HS`, `MD_U`) and the guest world (`MD_VS`, `MD_VU`), the block exchanges the whole foreground set with the whole background set in one clock cycle. An internal owner bit records which world's state is currently in the foreground. Machine mode belongs to neither world and never starts an exchange. On the next entry to a world mode, the block exchanges the sets if that owner bit does not match the world being entered.

A trap-on-supervisor-return control input lets machine software take over the return path. While it is set, a supervisor return request from `MD_HS` or `MD_VS` is turned into a trap to `MD_M`, and machine software can then perform the exchange itself.

Transitions of the mode machine:
- `T_GOTO`: a request with a valid code moves to the named state.
- `T_TSR`: a trapped supervisor return moves to `MD_M`.
- `T_HOLD`: no request, or an invalid code, leaves the state unchanged.

Top module: `banked_csr_swap`

## Requirements
- R1: After reset, every foreground and background register reads zero, `cur_mode` is 0 (`MD_M`) and `virt` is 0.
- R2: Mode codes are M=0, HS=1, U=2, VS=3, VU=4. When `mode_req` is high with a code in 0..4, `cur_mode` takes that code on the next cycle. A code in 5..7 is ignored and the mode is unchanged.
- R3: `virt` is 1 exactly when `cur_mode` is 3 or 4.
- R4: Address 0x140+i (i < NREGS) selects foreground register i. In a legal access, `csr_rdata` shows that register's current value in the same cycle, and a write (`csr_we`=1) is visible from the next cycle.
- R5: Address 0x240+i selects background register i with the same timing as R4. This access is legal only in M or HS.
- R6: When the target mode is in one world (HS/U versus VS/VU) and the foreground holds the other world's state, the full foreground and background sets are exchanged, effective on the next cycle.
- R7: Moves between VS and VU, between HS and U, and into M never exchange the sets.
- R8: A write issued in the same cycle as an exchanging transition lands in the set that was foreground when the write was issued.
- R9: `csr_illegal` is high in the cycle of any of these accesses: a background access from U, VS or VU; a foreground access from U or VU; or an address outside both windows. Such an access changes no register and reads zero.
- R10: With `tsr_en`=1, a `sret_req` in HS or VS raises `sret_trap` in the same cycle and moves the mode to M on the next cycle, with no exchange and overriding `mode_req`. In any other case `sret_trap` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Register access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, same cycle |
| csr_illegal | output | 1 | Access refused this cycle |
| mode_req | input | 1 | Mode change request |
| mode_next | input | 3 | Target mode code |
| sret_req | input | 1 | Supervisor return being executed |
| tsr_en | input | 1 | Trap supervisor returns to M |
| sret_trap | output | 1 | Supervisor return trapped this cycle |
| cur_mode | output | 3 | Current mode code |
| virt | output | 1 | Guest mode active |

## Verification
`csr_rdata`, `csr_illegal` and `sret_trap` depend only on the inputs and the current state, so they are due in the cycle of the stimulus. Mode changes, writes and exchanges take effect at the next rising edge. The bench drives each cycle's inputs at the falling edge and compares all outputs against a behavioural model shortly afterwards. It advances the model only after the rising edge, so every register effect is judged one cycle after it was issued.

// File: rtl/banked_csr_pkg.sv
package banked_csr_pkg;
    typedef enum logic [2:0] {
        MD_M  = 3'd0,
        MD_HS = 3'd1,
        MD_U  = 3'd2,
        MD_VS = 3'd3,
        MD_VU = 3'd4
    } mode_t;

    localparam logic [2:0] MODE_LAST = 3'd4;

    function automatic logic guest_world(mode_t m);
        return (m == MD_VS) || (m == MD_VU);
    endfunction
endpackage

// File: rtl/banked_csr_decode.sv
module banked_csr_decode
    import banked_csr_pkg::*;
#(
    parameter int          NREGS   = 4,
    parameter int          IDX_W   = 2,
    parameter logic [11:0] FG_BASE = 12'h140,
    parameter logic [11:0] BG_BASE = 12'h240
) (
    input  logic             req,
    input  logic             we,
    input  logic [11:0]      addr,
    input  mode_t            mode,
    output logic [IDX_W-1:0] idx,
    output logic             rd_fg,
    output logic             rd_bg,
    output logic             wr_fg,
    output logic             wr_bg,
    output logic             illegal
);
    localparam logic [11:0] SPAN = 12'(NREGS);

    logic [11:0] off_f, off_b;
    logic        in_f, in_b, fg_ok, bg_ok;

    always_comb begin
        off_f = addr - FG_BASE;
        off_b = addr - BG_BASE;
        in_f  = off_f < SPAN;
        in_b  = off_b < SPAN;
        unique case (mode)
            MD_M, MD_HS: begin fg_ok = 1'b1; bg_ok = 1'b1; end
            MD_VS:       begin fg_ok = 1'b1; bg_ok = 1'b0; end
            default:     begin fg_ok = 1'b0; bg_ok = 1'b0; end
        endcase
        idx     = in_f ? off_f[IDX_W-1:0] : off_b[IDX_W-1:0];
        rd_fg   = req && in_f && fg_ok;
        rd_bg   = req && in_b && bg_ok;
        wr_fg   = rd_fg && we;
        wr_bg   = rd_bg && we;
        illegal = req && !(rd_fg || rd_bg);
    end
endmodule

// File: rtl/banked_csr_mode.sv
module banked_csr_mode
    import banked_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_req,
    input  logic [2:0] mode_next,
    input  logic       sret_req,
    input  logic       tsr_en,
    output mode_t      state,
    output logic       virt,
    output logic       swap,
    output logic       sret_trap
);
    mode_t state_d;
    logic  guest_fg_q, guest_fg_d, trap_able;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= MD_M;
            guest_fg_q <= 1'b0;
        end else begin
            state      <= state_d;
            guest_fg_q <= guest_fg_d;
        end
    end

    // transitions and outputs
    always_comb begin
        unique case (state)
            MD_HS, MD_VS:       trap_able = 1'b1;
            MD_M, MD_U, MD_VU:  trap_able = 1'b0;
            default:            trap_able = 1'b0;
        endcase
        sret_trap = sret_req && tsr_en && trap_able;
        if (sret_trap)                                state_d = MD_M;              // T_TSR
        else if (mode_req && mode_next <= MODE_LAST)  state_d = mode_t'(mode_next); // T_GOTO
        else                                          state_d = state;             // T_HOLD
        swap       = (state_d != MD_M) && (state_d != state)
                     && (guest_world(state_d) != guest_fg_q);
        guest_fg_d = swap ? ~guest_fg_q : guest_fg_q;
        virt       = guest_world(state);
    end
endmodule

// File: rtl/banked_csr_bank.sv
module banked_csr_bank #(
    parameter int NREGS = 4,
    parameter int XLEN  = 32,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  rd_fg,
    input  logic                  rd_bg,
    input  logic                  wr_fg,
    input  logic                  wr_bg,
    input  logic [XLEN-1:0]       wdata,
    input  logic                  swap,
    output logic [XLEN-1:0]       rdata,
    output logic [NREGS*XLEN-1:0] fg_flat,
    output logic [NREGS*XLEN-1:0] bg_flat
);
    logic [XLEN-1:0] fg_q [NREGS];
    logic [XLEN-1:0] bg_q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_pair
        logic [XLEN-1:0] fg_w, bg_w;
        always_comb begin
            fg_w = (wr_fg && idx == IDX_W'(i)) ? wdata : fg_q[i];
            bg_w = (wr_bg && idx == IDX_W'(i)) ? wdata : bg_q[i];
        end
        // the write lands first, then the pair is exchanged
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fg_q[i] <= '0;
                bg_q[i] <= '0;
            end else if (swap) begin
                fg_q[i] <= bg_w;
                bg_q[i] <= fg_w;
            end else begin
                fg_q[i] <= fg_w;
                bg_q[i] <= bg_w;
            end
        end
        assign fg_flat[i*XLEN +: XLEN] = fg_q[i];
        assign bg_flat[i*XLEN +: XLEN] = bg_q[i];
    end

    always_comb begin
        if (rd_fg)      rdata = fg_q[idx];
        else if (rd_bg) rdata = bg_q[idx];
        else            rdata = '0;
    end
endmodule

// File: rtl/banked_csr_swap.sv
module banked_csr_swap
    import banked_csr_pkg::*;
#(
    parameter int NREGS = 4,
    parameter int XLEN  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_req,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    input  logic            mode_req,
    input  logic [2:0]      mode_next,
    input  logic            sret_req,
    input  logic            tsr_en,
    output logic            sret_trap,
    output logic [2:0]      cur_mode,
    output logic            virt
);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    mode_t                  state;
    logic                   swap, rd_fg, rd_bg, wr_fg, wr_bg;
    logic [IDX_W-1:0]       idx;
    logic [NREGS*XLEN-1:0]  fg_flat, bg_flat;

    banked_csr_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (mode_req),
        .mode_next (mode_next),
        .sret_req  (sret_req),
        .tsr_en    (tsr_en),
        .state     (state),
        .virt      (virt),
        .swap      (swap),
        .sret_trap (sret_trap)
    );

    banked_csr_decode #(.NREGS(NREGS), .IDX_W(IDX_W)) u_dec (
        .req     (csr_req),
        .we      (csr_we),
        .addr    (csr_addr),
        .mode    (state),
        .idx     (idx),
        .rd_fg   (rd_fg),
        .rd_bg   (rd_bg),
        .wr_fg   (wr_fg),
        .wr_bg   (wr_bg),
        .illegal (csr_illegal)
    );

    banked_csr_bank #(.NREGS(NREGS), .XLEN(XLEN), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .rd_fg   (rd_fg),
        .rd_bg   (rd_bg),
        .wr_fg   (wr_fg),
        .wr_bg   (wr_bg),
        .wdata   (csr_wdata),
        .swap    (swap),
        .rdata   (csr_rdata),
        .fg_flat (fg_flat),
        .bg_flat (bg_flat)
    );

    assign cur_mode = state;
endmodule

// File: rtl/banked_csr_swap_chk.sv
module banked_csr_swap_chk #(
    parameter int NREGS = 4,
    parameter int XLEN  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csr_req,
    input logic                  csr_illegal,
    input logic [XLEN-1:0]       csr_rdata,
    input logic                  mode_req,
    input logic [2:0]            mode_next,
    input logic                  sret_trap,
    input logic [2:0]            cur_mode,
    input logic                  swap,
    input logic                  wr_fg,
    input logic                  wr_bg,
    input logic [NREGS*XLEN-1:0] fg_flat,
    input logic [NREGS*XLEN-1:0] bg_flat
);
    AST_BAD_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && mode_next > 3'd4 && !sret_trap) |=> $stable(cur_mode)); // R2

    AST_EXCHANGE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !wr_fg && !wr_bg) |=> (fg_flat == $past(bg_flat) && bg_flat == $past(fg_flat))); // R6

    AST_GUEST_PAIR_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd3 && mode_req && mode_next == 3'd4 && !sret_trap) |-> !swap); // R7

    AST_REFUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0); // R9

    AST_REFUSED_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_illegal && !swap) |=> ($stable(fg_flat) && $stable(bg_flat))); // R9

    AST_TRAP_ENTERS_M: assert property (@(posedge clk) disable iff (!rst_n)
        sret_trap |=> cur_mode == 3'd0); // R10
endmodule

bind banked_csr_swap banked_csr_swap_chk #(.NREGS(NREGS), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_req     (csr_req),
    .csr_illegal (csr_illegal),
    .csr_rdata   (csr_rdata),
    .mode_req    (mode_req),
    .mode_next   (mode_next),
    .sret_trap   (sret_trap),
    .cur_mode    (cur_mode),
    .swap        (swap),
    .wr_fg       (wr_fg),
    .wr_bg       (wr_bg),
    .fg_flat     (fg_flat),
    .bg_flat     (bg_flat)
);

// File: tb/tb_banked_csr_swap.sv
module tb_banked_csr_swap;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 0, csr_we = 0, mode_req = 0, sret_req = 0, tsr_en = 0;
    logic [11:0] csr_addr = 0;
    logic [31:0] csr_wdata = 0;
    logic [2:0]  mode_next = 0;
    logic [31:0] csr_rdata;
    logic        csr_illegal, sret_trap, virt;
    logic [2:0]  cur_mode;

    int    n_tests = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R4";

    // reference model state
    logic [31:0] m_fg [NR];
    logic [31:0] m_bg [NR];
    int          m_mode;
    bit          m_guest_fg;

    banked_csr_swap #(.NREGS(NR), .XLEN(32)) dut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .mode_req(mode_req), .mode_next(mode_next),
        .sret_req(sret_req), .tsr_en(tsr_en), .sret_trap(sret_trap),
        .cur_mode(cur_mode), .virt(virt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit is_guest(int m);
        return m == 3 || m == 4;
    endfunction

    // window: 0 = foreground, 1 = background, 2 = unmapped
    function automatic int window(logic [11:0] a);
        if (a >= 12'h140 && a < 12'h140 + NR) return 0;
        if (a >= 12'h240 && a < 12'h240 + NR) return 1;
        return 2;
    endfunction

    function automatic bit allowed(logic [11:0] a, int m);
        case (window(a))
            0: return !(m == 2 || m == 4);
            1: return m == 0 || m == 1;
            default: return 0;
        endcase
    endfunction

    task automatic step(input logic rq, input logic we, input logic [11:0] a, input logic [31:0] wd,
                        input logic mrq, input logic [2:0] mn, input logic sr, input logic ts);
        bit ok, trap, sw;
        int nm, w, ix;
        logic [31:0] exp_rd, tmp;
        csr_req = rq; csr_we = we; csr_addr = a; csr_wdata = wd;
        mode_req = mrq; mode_next = mn; sret_req = sr; tsr_en = ts;
        #1;
        w  = window(a);
        ix = (w == 0) ? int'(a - 12'h140) : int'(a - 12'h240);
        ok = rq && allowed(a, m_mode);
        exp_rd = !ok ? 32'h0 : (w == 0 ? m_fg[ix] : m_bg[ix]);
        trap = sr && ts && (m_mode == 1 || m_mode == 3);
        chk("R2", "cur_mode", 32'(cur_mode), 32'(m_mode));
        chk("R3", "virt", 32'(virt), 32'(is_guest(m_mode)));
        chk("R9", "csr_illegal", 32'(csr_illegal), 32'(rq && !ok));
        chk(tag, "csr_rdata", csr_rdata, exp_rd);
        chk("R10", "sret_trap", 32'(sret_trap), 32'(trap));
        @(posedge clk);
        nm = trap ? 0 : ((mrq && mn <= 3'd4) ? int'(mn) : m_mode);
        if (ok && we) begin
            if (w == 0) m_fg[ix] = wd; else m_bg[ix] = wd;
        end
        sw = (nm != 0) && (nm != m_mode) && (is_guest(nm) != m_guest_fg);
        if (sw) begin
            for (int i = 0; i < NR; i++) begin
                tmp = m_fg[i]; m_fg[i] = m_bg[i]; m_bg[i] = tmp;
            end
            m_guest_fg = !m_guest_fg;
        end
        m_mode = nm;
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a);
        step(1, 0, a, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0, 0);
    endtask

    task automatic go(input logic [2:0] m);
        step(0, 0, 0, 0, 1, m, 0, 0);
    endtask

    task automatic read_all();
        for (int i = 0; i < NR; i++) rd(12'h140 + 12'(i));
        for (int i = 0; i < NR; i++) rd(12'h240 + 12'(i));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_fg[i] = 0; m_bg[i] = 0; end
        m_mode = 0; m_guest_fg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, read from M
        tag = "R1";
        read_all();
        // R4 / R5: fill both sets from M
        tag = "R4";
        for (int i = 0; i < NR; i++) wr(12'h140 + 12'(i), 32'hA000_0000 + i);
        tag = "R5";
        for (int i = 0; i < NR; i++) wr(12'h240 + 12'(i), 32'hB000_0000 + i);
        read_all();
        // R7: M -> HS keeps host state in foreground
        tag = "R7";
        go(3'd1);
        read_all();
        // R6: HS -> VS exchanges the sets
        tag = "R6";
        go(3'd3);
        read_all();
        // R9: guest supervisor cannot reach background
        tag = "R9";
        step(1, 1, 12'h241, 32'hDEAD, 0, 0, 0, 0);
        wr(12'h141, 32'hC111);
        // R7: VS <-> VU keeps the sets
        tag = "R7";
        go(3'd4);
        tag = "R9";
        step(1, 1, 12'h140, 32'hBAD0, 0, 0, 0, 0);
        step(1, 0, 12'h242, 0, 0, 0, 0, 0);
        step(1, 0, 12'h300, 0, 0, 0, 0, 0);
        go(3'd3);
        tag = "R7";
        rd(12'h141);
        // R8: write in the exchange cycle lands in the guest set
        tag = "R8";
        step(1, 1, 12'h142, 32'hC222, 1, 3'd1, 0, 0);
        read_all();
        // R7: HS <-> U, U is refused supervisor registers
        tag = "R9";
        go(3'd2);
        step(1, 0, 12'h140, 0, 0, 0, 0, 0);
        step(1, 1, 12'h240, 32'h1, 0, 0, 0, 0);
        // R6: U -> VU exchanges, VU -> M does not, M -> HS exchanges back
        tag = "R6";
        go(3'd4);
        go(3'd0);
        read_all();
        go(3'd1);
        read_all();
        // R2: invalid codes ignored
        step(0, 0, 0, 0, 1, 3'd6, 0, 0);
        step(0, 0, 0, 0, 1, 3'd7, 0, 0);
        // R10: trapped and untrapped supervisor returns
        tag = "R10";
        step(0, 0, 0, 0, 1, 3'd2, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1);
        go(3'd3);
        step(0, 0, 0, 0, 1, 3'd4, 1, 1);
        read_all();
        go(3'd1);
        step(0, 0, 0, 0, 0, 0, 1, 1);
        // mixed traffic against the model
        tag = "R6";
        for (int k = 0; k < 600; k++) begin
            logic [11:0] a;
            int sel = $urandom_range(0, 4);
            a = (sel < 2) ? 12'h140 + 12'($urandom_range(0, NR-1)) :
                (sel < 4) ? 12'h240 + 12'($urandom_range(0, NR-1)) : 12'h13F;
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom,
                 1'($urandom_range(0, 3) == 0), 3'($urandom_range(0, 6)),
                 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule